// File: doc/BRIEF.md
# Work Vector Dispatcher for Parallel Compute Cores

This block takes a stream of work vectors from an upstream generator, each a point or a run of points of an image, and hands each one to one of several parallel compute cores. The core is picked from those that report themselves ready at that moment, not from a fixed schedule. The aim is that every enabled core stays busy for as long as work keeps arriving.

The upstream side uses a valid/ready handshake. Each core has its own valid line and ready line, and all cores share one vector bus and one tag bus. The tag is a running sequence number, so logic further down can put results back in order. A count register chooses how many cores take part, from one up to all of them. After reset all cores are enabled. A new count is held back while a vector waits to be placed, so it only changes between vectors.

When several enabled cores are ready at once, the choice rotates. The search starts at the core after the one granted last, so no ready core is passed over for ever.

Top module: `work_dispatcher`

## Requirements
- R1: After reset the active count is NUM_CORES (all enabled), the sequence tag is 0, and the first vector goes to core 0 when every core is ready.
- R2: A vector offered while at least one enabled core is ready is accepted in that same cycle and goes to one of those ready enabled cores.
- R3: Among several ready enabled cores, the grant goes to the first one found searching upward (with wrap to core 0) from the core after the last granted core.
- R4: When no enabled core is ready, in_ready is low and every core_valid bit is low.
- R5: A count write stores max(1, min(value, NUM_CORES)): 0 acts as 1, and values above NUM_CORES act as NUM_CORES. A core whose index is at or above the active count never sees core_valid high.
- R6: A count written with cnt_wr_en becomes active no earlier than the cycle after the write, and never while a vector is offered and not accepted (in_valid high, in_ready low).
- R7: On each accepted vector exactly one core_valid bit is high, that core's ready is high, and core_vec equals in_vec. No vector is dropped or duplicated.
- R8: core_seq carries the tag of the offered vector. It starts at 0, rises by one for each accepted vector, and wraps modulo 2^SEQ_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| cnt_wr_en | input | 1 | Write strobe for the enabled-core count |
| cnt_wr_val | input | CNT_W | Requested number of enabled cores |
| in_valid | input | 1 | Upstream vector valid |
| in_ready | output | 1 | Upstream vector accepted this cycle when valid |
| in_vec | input | VEC_W | Upstream work vector |
| core_ready | input | NUM_CORES | Per-core ready |
| core_valid | output | NUM_CORES | Per-core vector valid, at most one set |
| core_vec | output | VEC_W | Vector bus shared by all cores |
| core_seq | output | SEQ_W | Sequence tag of the vector on the bus |

## Verification
The assertions assume that a core's ready line depends only on that core's own state and not on core_valid in the same cycle, so the grant path has no loop. They also assume that in_vec and in_valid come from registers, with reset released cleanly. The bench drives core_ready, in_valid, in_vec and the count strobe only on falling edges, using fixed patterns that never react to the outputs within a cycle. It samples a short time after those edges. Stalls are made by clearing the ready lines of the enabled cores, so that the "no enabled core ready" case is reached on purpose and does not arise from a race.

// File: rtl/wd_pkg.sv
package wd_pkg;

  // Clamp a requested core count into the legal range 1..lim.
  function automatic int unsigned clamp_count(input int unsigned req,
                                              input int unsigned lim);
    if (req == 0)   return 1;
    if (req > lim)  return lim;
    return req;
  endfunction

endpackage

// File: rtl/wd_count_reg.sv
module wd_count_reg #(
  parameter int N  = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          boundary,
  output logic [CW-1:0] active,
  output logic [N-1:0]  mask
);

  logic [CW-1:0] pending_q, pending_d;
  logic [CW-1:0] active_q,  active_d;

  always_comb begin
    pending_d = pending_q;
    if (wr_en)
      pending_d = CW'(wd_pkg::clamp_count(32'(wr_val), N));
  end

  always_comb begin
    active_d = active_q;
    if (boundary)
      active_d = pending_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= CW'(N);
      active_q  <= CW'(N);
    end else begin
      pending_q <= pending_d;
      active_q  <= active_d;
    end
  end

  assign active = active_q;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign mask[i] = (CW'(i) < active_q);
  end

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active_q));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != '0) && (active_q <= CW'(N)));

endmodule

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, last_d;
  logic          found;
  int            idx;

  always_comb begin
    grant = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (advance) begin
      for (int i = 0; i < N; i++)
        if (grant[i]) last_d = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  // R2
  grant_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $onehot(grant));

  // R3
  last_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(last_q));

endmodule

// File: rtl/wd_seq_ctr.sv
module wd_seq_ctr #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [SW-1:0] seq
);

  logic [SW-1:0] seq_q, seq_d;

  always_comb begin
    seq_d = seq_q;
    if (inc) seq_d = seq_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_d;
  end

  assign seq = seq_q;

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> seq_q == $past(seq_q) + SW'(1));

  // R8
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(seq_q));

endmodule

// File: rtl/work_dispatcher.sv
module work_dispatcher #(
  parameter  int NUM_CORES = 12,
  parameter  int VEC_W     = 32,
  parameter  int SEQ_W     = 8,
  localparam int CNT_W     = $clog2(NUM_CORES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_wr_en,
  input  logic [CNT_W-1:0]     cnt_wr_val,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [VEC_W-1:0]     in_vec,
  input  logic [NUM_CORES-1:0] core_ready,
  output logic [NUM_CORES-1:0] core_valid,
  output logic [VEC_W-1:0]     core_vec,
  output logic [SEQ_W-1:0]     core_seq
);

  logic [CNT_W-1:0]     active_cnt;
  logic [NUM_CORES-1:0] en_mask;
  logic [NUM_CORES-1:0] req;
  logic [NUM_CORES-1:0] grant;
  logic                 accept;
  logic                 boundary;

  assign req      = core_ready & en_mask;
  assign in_ready = |req;
  assign accept   = in_valid & in_ready;
  assign boundary = !in_valid || in_ready;

  wd_count_reg #(.N(NUM_CORES), .CW(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cnt_wr_en),
    .wr_val   (cnt_wr_val),
    .boundary (boundary),
    .active   (active_cnt),
    .mask     (en_mask)
  );

  wd_rr_pick #(.N(NUM_CORES)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .advance (accept),
    .grant   (grant)
  );

  wd_seq_ctr #(.SW(SEQ_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (accept),
    .seq   (core_seq)
  );

  assign core_valid = in_valid ? grant : '0;
  assign core_vec   = in_vec;

  // R7
  one_taker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $countones(core_valid & core_ready) == 1);

  // R7
  no_extra_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_valid));

  // R5
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid & ~en_mask) == '0);

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_ready & en_mask) == '0) |-> (!in_ready && core_valid == '0));

endmodule

// File: tb/work_dispatcher_test.sv
module work_dispatcher_test;

  localparam int N  = 12;
  localparam int VW = 32;
  localparam int SW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_wr_en;
  logic [CW-1:0] cnt_wr_val;
  logic          in_valid;
  logic          in_ready;
  logic [VW-1:0] in_vec;
  logic [N-1:0]  core_ready;
  logic [N-1:0]  core_valid;
  logic [VW-1:0] core_vec;
  logic [SW-1:0] core_seq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int       m_last = N - 1;
  int       m_cnt  = N;
  logic [SW-1:0] m_seq = '0;

  always #10 clk = ~clk;

  work_dispatcher #(.NUM_CORES(N), .VEC_W(VW), .SEQ_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
    .core_ready(core_ready), .core_valid(core_valid),
    .core_vec(core_vec), .core_seq(core_seq)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [N-1:0] rdy);
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_last + k) % N;
      if (rdy[idx] && idx < m_cnt) return idx;
    end
    return -1;
  endfunction

  // Offer one vector for one cycle and check the dispatch.
  task automatic send(input string req, input logic [N-1:0] rdy,
                      input logic [VW-1:0] data);
    int e;
    @(negedge clk);
    in_valid = 1'b1; in_vec = data; core_ready = rdy;
    #2;
    e = pick(rdy);
    check(req, 32'(in_ready), (e >= 0) ? 32'd1 : 32'd0);
    check(req, 32'(core_valid), (e >= 0) ? (32'd1 << e) : 32'd0);
    check(req, 32'(core_seq), 32'(m_seq));
    check(req, core_vec, data);
    if (e >= 0) begin
      m_last = e;
      m_seq  = m_seq + 1'b1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; cnt_wr_en = 1'b0;
  endtask

  task automatic set_count(input logic [CW-1:0] v, input int eff);
    @(negedge clk);
    in_valid = 1'b0; cnt_wr_en = 1'b1; cnt_wr_val = v;
    idle();
    idle();
    m_cnt = eff;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    check("R1 seq", 32'(core_seq), 0);
    check("R1 valid idle", 32'(core_valid), 0);
    // only the top core ready: all cores enabled by default
    core_ready = 12'h800;
    #1;
    check("R1 top core enabled", 32'(in_ready), 1);
    send("R1 first grant core0", '1, 32'hA000_0000);
    idle();
  endtask

  task automatic t_rotate();
    for (int i = 0; i < 14; i++) send("R3 rotate all ready", '1, 32'hB000_0000 + 32'(i));
    send("R3 skip to next ready", 12'b1000_0010_0100, 32'hB100_0000);
    send("R3 wrap search", 12'b0000_0010_0001, 32'hB100_0001);
    send("R2 single ready core", 12'b0000_1000_0000, 32'hB100_0002);
    idle();
  endtask

  task automatic t_stall();
    send("R4 no core ready", '0, 32'hC000_0000);
    send("R4 stall held", '0, 32'hC000_0000);
    send("R7 release after stall", 12'b0000_0000_0010, 32'hC000_0000);
    idle();
    #2;
    check("R7 no duplicate", 32'(core_valid), 0);
  endtask

  task automatic t_clamp();
    set_count(4'd0, 1);
    for (int i = 0; i < 3; i++) send("R5 zero acts as one", '1, 32'hD000_0000 + 32'(i));
    set_count(4'd15, N);
    send("R5 over range acts as max", 12'h800, 32'hD100_0000);
    set_count(4'd4, 4);
    send("R5 disabled core ignored", 12'h200, 32'hD200_0000);
    send("R5 enabled subset rotates", '1, 32'hD200_0001);
    send("R5 enabled subset rotates", '1, 32'hD200_0002);
    idle();
  endtask

  task automatic t_boundary();
    set_count(4'd2, 2);
    // vector waits; count write must not apply while it waits
    @(negedge clk);
    in_valid = 1'b1; in_vec = 32'hE000_0000; core_ready = 12'h020;
    cnt_wr_en = 1'b1; cnt_wr_val = 4'd12;
    #2;
    check("R6 stall before write", 32'(in_ready), 0);
    @(negedge clk);
    cnt_wr_en = 1'b0;
    #2;
    check("R6 count held while waiting", 32'(in_ready), 0);
    check("R6 no valid to core5", 32'(core_valid), 0);
    send("R6 dispatch at old count", 12'h022, 32'hE000_0000);
    m_cnt = N;
    send("R6 new count after boundary", 12'h020, 32'hE000_0001);
    idle();
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_vec = 32'(i); core_ready = '1;
      #2;
      if (core_seq !== m_seq) check("R8 tag sequence", 32'(core_seq), 32'(m_seq));
      m_seq  = m_seq + 1'b1;
      m_last = pick('1);
    end
    check("R8 tag after wrap", 32'(m_seq), 32'(core_seq) + 1);
    idle();
  endtask

  initial begin
    rst_n = 1'b0; cnt_wr_en = 1'b0; cnt_wr_val = '0;
    in_valid = 1'b0; in_vec = '0; core_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rotate();
    t_stall();
    t_clamp();
    t_boundary();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule